// File: doc/BRIEF.md
# Modem Line Status Register with Change Flags

This block watches four active-low modem handshake pins (clear-to-send, data-set-ready, ring indicator and carrier detect) and shows them to a host as one 8-bit status byte. The high nibble gives the present logical level of each line, inverted so that an asserted (low) pin reads as 1. The low nibble holds sticky change flags that record line activity between reads. A host read strobe clears these flags.

Three of the lines (data-set-ready, ring, carrier) share pins with general-purpose I/O. They count as modem lines only while the modem-mode select input is high. Clear-to-send is always a modem line. Each raw pin passes through a two-stage synchronizer before any edge is detected. An interrupt request is raised while any change flag is set and the interrupt enable is high.

The block has no streaming data path. The read strobe, the read data, the mode select, the enable and the interrupt are plain level signals, with no handshake and no back-pressure. Read data is valid in the same cycle as the strobe, and the strobe takes effect at the next rising clock edge.

Top module: `modem_status_reg`

## Requirements
- R1: Read data bits 4, 5, 6 and 7 show the inverse of the synchronized clear-to-send, data-set-ready, ring and carrier pins, in that order. A pin change shows there on the second rising clock edge after it.
- R2: Bit 0 is set on the third rising edge after the clear-to-send pin changes in either direction, and stays set until it is cleared.
- R3: Bit 1 (data-set-ready) and bit 3 (carrier) are set by a change of their pin in either direction, with the same latency as R2.
- R4: Bit 2 is set only when the ring pin goes from low to high. A high-to-low ring transition leaves it unchanged.
- R5: When rd_i is high at a rising edge, bits 3 to 0 are 0 after that edge, unless R6 applies.
- R6: A change flag whose event is detected in the same cycle as a read stays set after that edge.
- R7: While modem_sel_i is low, bits 7 to 5 read 0 and bits 3 to 1 cannot become set. Bits 4 and 0 work as usual.
- R8: irq_o is high exactly when msi_en_i is high and any of bits 3 to 0 is set.
- R9: Reset clears all change flags and loads the current pin levels into the synchronizer. After reset is released, no flag sets unless a pin changes.

Ports

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, shared with GPIO |
| ri_n_i | input | 1 | Ring indicator pin, active low, shared with GPIO |
| cd_n_i | input | 1 | Carrier detect pin, active low, shared with GPIO |
| modem_sel_i | input | 1 | 1 selects modem use of the three shared pins |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| rd_i | input | 1 | Register read strobe |
| rd_data_o | output | 8 | Status byte: 7 carrier, 6 ring, 5 dsr, 4 cts, 3 dCD, 2 ring trailing edge, 1 dDSR, 0 dCTS |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- a detected event always leaves its flag set after the edge, even under a read;
- a read with no event clears the flag;
- the synchronizer outputs show no edge on the first cycle after reset;
- a shared-pin flag cannot rise while modem mode is off;
- the interrupt never rises while it is masked or while all flags are clear.

Some behaviour only the bench can show, because it needs an independent reference running over long random pin, mode and read sequences. This covers the exact two- and three-edge latencies and the trailing-edge-only rule for ring. It also covers the status values after a reset taken with pins already asserted.

// File: rtl/modem_stat_pkg.sv
package modem_stat_pkg;
  localparam int NLINES = 4;
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_CD  = 3;

  typedef enum logic {
    EDGE_ANY  = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/msr_pin_sync.sv
module msr_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] hist_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] chain [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        chain[s] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) chain[s] <= pin_i;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign hist_o = chain[STAGES];

  // R9: history primed from pins, so no edge is seen right after reset
  a_r9_quiet_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (lvl_o == hist_o));
endmodule

// File: rtl/msr_delta_flag.sv
module msr_delta_flag
  import modem_stat_pkg::*;
#(
  parameter edge_kind_e EDGE_KIND = EDGE_ANY
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  input  logic hist_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic flag_o
);
  logic evt;

  if (EDGE_KIND == EDGE_RISE) begin : g_rise
    assign evt = arm_i & lvl_i & ~hist_i;
  end else begin : g_any
    assign evt = arm_i & (lvl_i ^ hist_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) flag_o <= 1'b0;
    else       flag_o <= (flag_o & ~clr_i) | evt;
  end

  // R6: an event is never lost, even under a read
  a_r6_event_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    evt |=> flag_o);
  // R5: read without a new event clears the flag
  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !evt) |=> !flag_o);
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import modem_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       cd_n_i,
  input  logic       modem_sel_i,
  input  logic       msi_en_i,
  input  logic       rd_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o
);
  logic [NLINES-1:0] pins, lvl, hist, arm, flags, state;

  always_comb begin
    pins         = '0;
    pins[LN_CTS] = cts_n_i;
    pins[LN_DSR] = dsr_n_i;
    pins[LN_RI]  = ri_n_i;
    pins[LN_CD]  = cd_n_i;
  end

  msr_pin_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pin_i  (pins),
    .lvl_o  (lvl),
    .hist_o (hist)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    localparam bit         DEDICATED = (i == LN_CTS);
    localparam edge_kind_e KIND      = (i == LN_RI) ? EDGE_RISE : EDGE_ANY;

    assign arm[i]   = DEDICATED ? 1'b1 : modem_sel_i;
    assign state[i] = arm[i] & ~lvl[i];

    msr_delta_flag #(.EDGE_KIND(KIND)) u_flag (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .lvl_i  (lvl[i]),
      .hist_i (hist[i]),
      .arm_i  (arm[i]),
      .clr_i  (rd_i),
      .flag_o (flags[i])
    );
  end

  assign rd_data_o = {state, flags};
  assign irq_o     = msi_en_i & (|flags);

  // R7: shared-pin flags cannot rise while modem mode is off
  a_r7_no_gpio_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    !modem_sel_i |=> !($rose(flags[LN_DSR]) || $rose(flags[LN_RI]) || $rose(flags[LN_CD])));
  // R8: masked interrupt stays low
  a_r8_irq_masked: assert property (@(posedge clk_i) disable iff (rst_i)
    !msi_en_i |-> !irq_o);
  // R8: interrupt implies a pending change flag on the read port
  a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (rd_data_o[3:0] != 4'h0));
endmodule

// File: tb/sim_modem_status_reg.sv
module sim_modem_status_reg;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic sel = 1'b1, en = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic irq;

  int checks = 0;
  int fails  = 0;

  logic [3:0] p1, p2, p3, mflag;

  always #(PERIOD/2) clk = ~clk;

  modem_status_reg u0 (
    .clk_i(clk), .rst_i(rst), .cts_n_i(cts_n), .dsr_n_i(dsr_n),
    .ri_n_i(ri_n), .cd_n_i(cd_n), .modem_sel_i(sel), .msi_en_i(en),
    .rd_i(rd), .rd_data_o(rdata), .irq_o(irq)
  );

  function automatic logic [3:0] pin_vec();
    return {cd_n, ri_n, dsr_n, cts_n};
  endfunction

  function automatic logic [3:0] arm_vec(input logic s);
    return {s, s, s, 1'b1};
  endfunction

  function automatic logic [7:0] exp_data();
    return {~p2 & arm_vec(sel), mflag};
  endfunction

  function automatic string bit_tag(input int b);
    if (b >= 5 && !sel) return "R7";
    if (b >= 4)         return "R1";
    if (b == 0)         return "R2";
    if (b == 2)         return "R4";
    return "R3";
  endfunction

  task automatic model_edge();
    logic [3:0] evt;
    if (rst) begin
      p1 = pin_vec(); p2 = pin_vec(); p3 = pin_vec(); mflag = '0;
    end else begin
      evt    = arm_vec(sel) & (p2 ^ p3);
      evt[2] = sel & p2[2] & ~p3[2];
      mflag  = (mflag & ~{4{rd}}) | evt;
      p3 = p2; p2 = p1; p1 = pin_vec();
    end
  endtask

  task automatic compare(input string tag);
    logic [7:0] e;
    logic       ei;
    string      t;
    e  = exp_data();
    ei = en & (|mflag);
    checks++;
    if (rdata !== e) begin
      t = tag;
      if (t == "")
        for (int b = 7; b >= 0; b--)
          if (rdata[b] !== e[b]) t = bit_tag(b);
      fails++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", t, rdata, e);
    end
    checks++;
    if (irq !== ei) begin
      fails++;
      $display("FAIL R8 irq actual=%0b expected=%0b", irq, ei);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R9: reset with all pins asserted (low)
    cts_n = 0; dsr_n = 0; ri_n = 0; cd_n = 0; sel = 1; en = 1;
    repeat (3) step("R9");
    @(negedge clk); rst = 0;
    checks++;
    if (rdata !== 8'hF0) begin
      fails++; $display("FAIL R9 rd_data actual=%02h expected=f0", rdata);
    end
    repeat (4) step("R9");

    // R2/R5: toggle cts, see flag, then read clears
    cts_n = 1;
    repeat (4) step("");
    checks++;
    if (rdata[0] !== 1'b1) begin
      fails++; $display("FAIL R2 dcts actual=%0b expected=1", rdata[0]);
    end
    rd = 1; step("R5"); rd = 0; step("R5");

    // R4: ring falling edge sets nothing, rising edge sets bit 2
    ri_n = 0; repeat (4) step("R4");
    ri_n = 1; repeat (4) step("R4");
    rd = 1; step("R5"); rd = 0;

    // R6: read held while an event arrives
    dsr_n = ~dsr_n; rd = 1;
    repeat (5) step("R6");
    rd = 0; step("R6");

    // R7: mode off, shared pins toggle
    sel = 0;
    for (int k = 0; k < 6; k++) begin
      dsr_n = ~dsr_n; cd_n = ~cd_n; ri_n = ~ri_n;
      step("R7");
    end
    sel = 1; repeat (4) step("R7");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(3) == 0) cts_n = ~cts_n;
      if ($urandom_range(3) == 0) dsr_n = ~dsr_n;
      if ($urandom_range(3) == 0) ri_n  = ~ri_n;
      if ($urandom_range(3) == 0) cd_n  = ~cd_n;
      if ($urandom_range(15) == 0) sel  = ~sel;
      if ($urandom_range(7) == 0)  en   = ~en;
      rd = ($urandom_range(4) == 0);
      step("");
    end

    // R9: mid-run reset then quiet
    rst = 1; step("R9"); step("R9");
    @(negedge clk); rst = 0; rd = 0;
    repeat (5) step("R9");
    summary();
  end
endmodule